// File: doc/BRIEF.md
# Calendar Clock with Field-Masked Alarm and Interval Timer

This block keeps wall-clock time and date: second, minute, hour, day of month, month, a two-digit year and a day-of-week index. A one-cycle enable pulse that arrives once per second advances it. Month lengths come from the current month and year, and February gets its extra day in leap years with no help from software. Software sets time fields, alarm settings and the interval timer through a single-cycle write strobe that carries an address and a data byte. Any field can be rewritten while the count keeps running.

The alarm compares selected fields of the updated time against programmed values on every second tick. Each field has its own enable bit, so a match can cover the full date and time or only some fields. A separate interval timer counts seconds after it is programmed and signals once, or again at every interval. Each interrupt source gives a one-cycle pulse and sets a sticky flag, which stays up until its clear input is raised.

Top module: `calclk_rtc`

## Requirements
- R1: After reset the outputs read second 0, minute 0, hour 0, day 1, month 1, year 1, day-of-week 0, and both pulses and both flags read 0.
- R2: Each `tick_1hz` advances the second. Second 59 rolls to 0 and carries into the minute. Minute 59 rolls to 0 and carries into the hour. Hour 23 rolls to 0 and carries into the day. Without a tick and without a write, no time field changes.
- R3: A carry into a day that is at or past the month length gives day 1 and carries into the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 days in a common year, and all other months have 31.
- R4: When the year value is divisible by 4, February has 29 days. The year is binary 1..99 and there is no century exception.
- R5: A carry into month 12 gives month 1 and carries into the year. A carry into year 99 gives year 1.
- R6: The day-of-week field counts 0..6 and wraps to 0. It advances exactly when the day of month is advanced by a carry.
- R7: A write with address 0..6 (second, minute, hour, day, month, year, day-of-week) loads `wr_data[6:0]` into that field at the next edge. If a tick falls in the same cycle, the written value wins, that field is not advanced and passes no carry upward, and the lower fields still count.
- R8: Addresses 8..14 hold the alarm compare values in the same field order. Address 7 holds the enable mask, with bit i enabling field i. `alarm_irq` is high for the one cycle after a tick whose updated time matches every enabled field. A mask of zero never fires. A match uses the alarm settings held before any write in the same cycle.
- R9: `alarm_flag` is set by an alarm pulse and stays set until `alarm_clr` is high. A pulse in the same cycle as a clear leaves the flag set.
- R10: A write to address 15 loads the timer period from `wr_data[6:0]` and repeat mode from `wr_data[7]`, and restarts the count. `timer_irq` pulses in the cycle after the period-th following tick. In one-shot mode the timer then stops; in repeat mode it reloads. A period of 0 stops the timer.
- R11: `timer_flag` is set by a timer pulse and stays set until `timer_clr` is high. A pulse in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address (time 0..6, alarm mask 7, alarm values 8..14, timer 15) |
| wr_data | input | 8 | Write data |
| alarm_clr | input | 1 | Clears the alarm flag |
| timer_clr | input | 1 | Clears the timer flag |
| sec_o | output | 7 | Second 0..59 |
| min_o | output | 7 | Minute 0..59 |
| hour_o | output | 7 | Hour 0..23 |
| day_o | output | 7 | Day of month 1..31 |
| mon_o | output | 7 | Month 1..12 |
| year_o | output | 7 | Year 1..99 |
| wday_o | output | 3 | Day of week 0..6 |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| alarm_flag | output | 1 | Sticky alarm flag |
| timer_irq | output | 1 | One-cycle timer pulse |
| timer_flag | output | 1 | Sticky timer flag |

## Verification
The second tick and a software write can land in the same cycle. The outcome then depends on which field was written and whether a carry was on its way into that field. The bench causes this collision on purpose: it rewrites the minute while the second sits at 59, and it writes the second itself during a tick. Later, a random phase draws writes and ticks independently, so collisions on every field, the alarm registers and the timer happen repeatedly. A behavioural model applies the write-wins and carry-suppression rule, and every output is compared against it on every clock.

// File: rtl/calclk_pkg.sv
package calclk_pkg;
   localparam int unsigned NFLD = 7;
   localparam int unsigned FW   = 7;

   localparam int FLD_SEC  = 0;
   localparam int FLD_MIN  = 1;
   localparam int FLD_HOUR = 2;
   localparam int FLD_DAY  = 3;
   localparam int FLD_MON  = 4;
   localparam int FLD_YEAR = 5;
   localparam int FLD_WDAY = 6;

   // lowest legal value of a field
   function automatic logic [FW-1:0] fld_base(input int idx);
      return (idx == FLD_DAY || idx == FLD_MON || idx == FLD_YEAR) ? FW'(1) : FW'(0);
   endfunction

   // highest legal value of a field (day handled by month_len)
   function automatic logic [FW-1:0] fld_top(input int idx, input int ymax);
      case (idx)
         FLD_SEC, FLD_MIN: return FW'(59);
         FLD_HOUR:         return FW'(23);
         FLD_MON:          return FW'(12);
         FLD_YEAR:         return FW'(ymax);
         FLD_WDAY:         return FW'(6);
         default:          return FW'(31);
      endcase
   endfunction

   function automatic logic [FW-1:0] month_len(input logic [FW-1:0] mon,
                                                input logic [1:0]    yr_lo);
      case (mon)
         FW'(2):                          return (yr_lo == 2'b00) ? FW'(29) : FW'(28);
         FW'(4), FW'(6), FW'(9), FW'(11): return FW'(30);
         default:                         return FW'(31);
      endcase
   endfunction
endpackage

// File: rtl/calclk_chain.sv
module calclk_chain
   import calclk_pkg::*;
#(
   parameter int YEAR_MAX = 99,
   parameter int AW       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_addr,
   input  logic [FW-1:0]                 wr_val,
   output logic [NFLD-1:0][FW-1:0]       tm_q,
   output logic [NFLD-1:0][FW-1:0]       tm_d
);
   logic [NFLD-1:0] hit;
   logic [NFLD-1:0] roll;
   logic [NFLD-1:0] step_in;
   logic [FW-1:0]   day_top;

   assign day_top    = month_len(tm_q[FLD_MON], tm_q[FLD_YEAR][1:0]);
   assign step_in[0] = tick;

   generate
      for (genvar g = 0; g < NFLD; g++) begin : g_fld
         logic [FW-1:0] top_v;
         logic [FW-1:0] bump;

         assign hit[g] = wr_en && (wr_addr == AW'(g));

         if (g == FLD_DAY) begin : g_dtop
            assign top_v = day_top;
         end else begin : g_ftop
            assign top_v = fld_top(g, YEAR_MAX);
         end

         assign roll[g] = (tm_q[g] >= top_v);
         assign bump    = roll[g] ? fld_base(g) : tm_q[g] + FW'(1);

         if (g == FLD_WDAY) begin : g_wstep
            assign step_in[g] = step_in[FLD_DAY] & ~hit[FLD_DAY];
         end else if (g > 0) begin : g_cstep
            assign step_in[g] = step_in[g-1] & roll[g-1] & ~hit[g-1];
         end

         assign tm_d[g] = hit[g] ? wr_val : (step_in[g] ? bump : tm_q[g]);

         always_ff @(posedge clk) begin
            if (!rst_n) tm_q[g] <= fld_base(g);
            else        tm_q[g] <= tm_d[g];
         end
      end
   endgenerate

   // R2
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en) |=> (tm_q[FLD_SEC] ==
         (($past(tm_q[FLD_SEC]) >= FW'(59)) ? FW'(0) : $past(tm_q[FLD_SEC]) + FW'(1))));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(tm_q));
   // R4
   leap_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && tm_q[FLD_MON] == FW'(2) && tm_q[FLD_DAY] == FW'(28) &&
       tm_q[FLD_YEAR][1:0] == 2'b00 && tm_q[FLD_HOUR] == FW'(23) &&
       tm_q[FLD_MIN] == FW'(59) && tm_q[FLD_SEC] == FW'(59))
      |=> (tm_q[FLD_DAY] == FW'(29)));
   // R5
   year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && tm_q[FLD_YEAR] == FW'(YEAR_MAX) && tm_q[FLD_MON] == FW'(12) &&
       tm_q[FLD_DAY] == FW'(31) && tm_q[FLD_HOUR] == FW'(23) &&
       tm_q[FLD_MIN] == FW'(59) && tm_q[FLD_SEC] == FW'(59))
      |=> (tm_q[FLD_YEAR] == FW'(1) && tm_q[FLD_MON] == FW'(1)));
   // R7
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr < AW'(NFLD)) |=> (tm_q[$past(wr_addr[2:0])] == $past(wr_val)));
endmodule

// File: rtl/calclk_alarm.sv
module calclk_alarm
   import calclk_pkg::*;
#(
   parameter int AW        = 4,
   parameter int MASK_ADDR = 7,
   parameter int VAL_BASE  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [FW-1:0]           wr_val,
   input  logic [NFLD-1:0][FW-1:0] tm_d,
   input  logic                    clr,
   output logic                    irq,
   output logic                    flag
);
   logic [NFLD-1:0] en_q;
   logic [NFLD-1:0] ok;
   logic            fire;

   always_ff @(posedge clk) begin
      if (!rst_n)                                      en_q <= '0;
      else if (wr_en && wr_addr == AW'(MASK_ADDR))     en_q <= wr_val[NFLD-1:0];
   end

   generate
      for (genvar g = 0; g < NFLD; g++) begin : g_cmp
         logic [FW-1:0] ref_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                       ref_q <= '0;
            else if (wr_en && wr_addr == AW'(VAL_BASE + g))   ref_q <= wr_val;
         end
         assign ok[g] = ~en_q[g] | (tm_d[g] == ref_q);
      end
   endgenerate

   assign fire = tick & (|en_q) & (&ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         flag <= 1'b0;
      end else begin
         irq  <= fire;
         flag <= fire | (flag & ~clr);
      end
   end

   // R8
   alm_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick));
   // R9
   alm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
   // R9
   alm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/calclk_timer.sv
module calclk_timer #(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int TM_ADDR = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          clr,
   output logic          irq,
   output logic          flag
);
   localparam int TW = DW - 1;

   logic [TW-1:0] per_q, cnt_q, cnt_d;
   logic          rep_q, fire, hit;

   assign hit = wr_en && (wr_addr == AW'(TM_ADDR));

   always_comb begin
      fire  = 1'b0;
      cnt_d = cnt_q;
      if (hit) begin
         cnt_d = wr_data[TW-1:0];
      end else if (tick && cnt_q != '0) begin
         if (cnt_q == TW'(1)) begin
            fire  = 1'b1;
            cnt_d = rep_q ? per_q : '0;
         end else begin
            cnt_d = cnt_q - TW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= '0;
         rep_q <= 1'b0;
         cnt_q <= '0;
         irq   <= 1'b0;
         flag  <= 1'b0;
      end else begin
         if (hit) begin
            per_q <= wr_data[TW-1:0];
            rep_q <= wr_data[DW-1];
         end
         cnt_q <= cnt_d;
         irq   <= fire;
         flag  <= fire | (flag & ~clr);
      end
   end

   // R10
   tmr_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick));
   // R10
   tmr_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !rep_q) |=> (cnt_q == '0));
   // R11
   tmr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/calclk_rtc.sv
module calclk_rtc
   import calclk_pkg::*;
#(
   parameter int YEAR_MAX = 99,
   parameter int AW       = 4,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_1hz,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          alarm_clr,
   input  logic          timer_clr,
   output logic [FW-1:0] sec_o,
   output logic [FW-1:0] min_o,
   output logic [FW-1:0] hour_o,
   output logic [FW-1:0] day_o,
   output logic [FW-1:0] mon_o,
   output logic [FW-1:0] year_o,
   output logic [2:0]    wday_o,
   output logic          alarm_irq,
   output logic          alarm_flag,
   output logic          timer_irq,
   output logic          timer_flag
);
   localparam int MASK_ADDR = NFLD;
   localparam int VAL_BASE  = NFLD + 1;
   localparam int TM_ADDR   = 2 * NFLD + 1;

   initial begin
      assert (YEAR_MAX >= 4 && YEAR_MAX < (1 << FW)) else $error("YEAR_MAX out of range");
      assert (DW > FW) else $error("DW must exceed field width");
      assert ((1 << AW) > TM_ADDR) else $error("AW too small for address map");
   end

   logic [NFLD-1:0][FW-1:0] tm_q, tm_d;

   calclk_chain #(.YEAR_MAX(YEAR_MAX), .AW(AW)) chain_i (
      .clk, .rst_n, .tick(tick_1hz), .wr_en, .wr_addr,
      .wr_val(wr_data[FW-1:0]), .tm_q, .tm_d
   );

   calclk_alarm #(.AW(AW), .MASK_ADDR(MASK_ADDR), .VAL_BASE(VAL_BASE)) alarm_i (
      .clk, .rst_n, .tick(tick_1hz), .wr_en, .wr_addr,
      .wr_val(wr_data[FW-1:0]), .tm_d, .clr(alarm_clr),
      .irq(alarm_irq), .flag(alarm_flag)
   );

   calclk_timer #(.AW(AW), .DW(DW), .TM_ADDR(TM_ADDR)) timer_i (
      .clk, .rst_n, .tick(tick_1hz), .wr_en, .wr_addr, .wr_data,
      .clr(timer_clr), .irq(timer_irq), .flag(timer_flag)
   );

   assign sec_o  = tm_q[FLD_SEC];
   assign min_o  = tm_q[FLD_MIN];
   assign hour_o = tm_q[FLD_HOUR];
   assign day_o  = tm_q[FLD_DAY];
   assign mon_o  = tm_q[FLD_MON];
   assign year_o = tm_q[FLD_YEAR];
   assign wday_o = tm_q[FLD_WDAY][2:0];
endmodule

// File: tb/calclk_rtc_tb_top.sv
module calclk_rtc_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1hz = 1'b0, wr_en = 1'b0, alarm_clr = 1'b0, timer_clr = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [6:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
   logic [2:0] wday_o;
   logic alarm_irq, alarm_flag, timer_irq, timer_flag;

   always #4 clk = ~clk;

   calclk_rtc dut_i (
      .clk, .rst_n, .tick_1hz, .wr_en, .wr_addr, .wr_data, .alarm_clr, .timer_clr,
      .sec_o, .min_o, .hour_o, .day_o, .mon_o, .year_o, .wday_o,
      .alarm_irq, .alarm_flag, .timer_irq, .timer_flag
   );

   int vectors = 0;
   int fails = 0;
   bit started = 0;
   bit done = 0;

   // reference model state
   int m[7], nx[7], am[7];
   int amask, tper, tcnt, trep;
   bit m_airq, m_aflag, m_tirq, m_tflag;
   bit carry, dayadv, fa, ft, okall;
   int lim;

   function automatic int mlen(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic int lowest(int i);
      return (i >= 3 && i <= 5) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m = '{0, 0, 0, 1, 1, 1, 0};
         am = '{0, 0, 0, 0, 0, 0, 0};
         amask = 0; tper = 0; tcnt = 0; trep = 0;
         m_airq = 0; m_aflag = 0; m_tirq = 0; m_tflag = 0;
      end else begin
         nx = m;
         carry = tick_1hz;
         dayadv = 0;
         for (int i = 0; i < 6; i++) begin
            if (i == 3) dayadv = carry && !(wr_en && wr_addr == 3);
            if (carry) begin
               case (i)
                  0, 1: lim = 59;
                  2: lim = 23;
                  3: lim = mlen(m[4], m[5]);
                  4: lim = 12;
                  default: lim = 99;
               endcase
               if (m[i] >= lim) nx[i] = lowest(i);
               else begin nx[i] = m[i] + 1; carry = 0; end
            end
            if (wr_en && wr_addr == i) begin nx[i] = wr_data & 127; carry = 0; end
         end
         if (wr_en && wr_addr == 6) nx[6] = wr_data & 127;
         else if (dayadv) nx[6] = (m[6] >= 6) ? 0 : m[6] + 1;
         // alarm uses settings before this edge's write
         okall = 1;
         for (int i = 0; i < 7; i++)
            if (((amask >> i) & 1) && nx[i] != am[i]) okall = 0;
         fa = tick_1hz && amask != 0 && okall;
         if (wr_en && wr_addr == 7) amask = wr_data & 127;
         if (wr_en && wr_addr >= 8 && wr_addr <= 14) am[wr_addr - 8] = wr_data & 127;
         // timer
         ft = 0;
         if (wr_en && wr_addr == 15) begin
            tper = wr_data & 127; trep = wr_data >> 7; tcnt = tper;
         end else if (tick_1hz && tcnt != 0) begin
            if (tcnt == 1) begin ft = 1; tcnt = trep ? tper : 0; end
            else tcnt = tcnt - 1;
         end
         m_aflag = fa || (m_aflag && !alarm_clr);
         m_tflag = ft || (m_tflag && !timer_clr);
         m_airq = fa;
         m_tirq = ft;
         m = nx;
      end
   end

   task automatic cmp(string tag, string what, int act, int exp);
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (started && !done) begin
         vectors++;
         cmp("R2", "sec", sec_o, m[0]);
         cmp("R2", "min", min_o, m[1]);
         cmp("R2", "hour", hour_o, m[2]);
         cmp("R3", "day", day_o, m[3]);
         cmp("R5", "month", mon_o, m[4]);
         cmp("R5", "year", year_o, m[5]);
         cmp("R6", "wday", wday_o, m[6]);
         cmp("R8", "alarm_irq", alarm_irq, m_airq);
         cmp("R9", "alarm_flag", alarm_flag, m_aflag);
         cmp("R10", "timer_irq", timer_irq, m_tirq);
         cmp("R11", "timer_flag", timer_flag, m_tflag);
      end
   end

   task automatic dchk(string tag, string what, int act, int exp);
      vectors++;
      cmp(tag, what, act, exp);
   endtask

   task automatic cyc(bit t, bit we, int a, int d);
      @(negedge clk);
      tick_1hz = t; wr_en = we; wr_addr = 4'(a); wr_data = 8'(d);
      alarm_clr = 0; timer_clr = 0;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0);
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s, int w);
      cyc(0, 1, 5, y); cyc(0, 1, 4, mo); cyc(0, 1, 3, d);
      cyc(0, 1, 2, h); cyc(0, 1, 1, mi); cyc(0, 1, 0, s); cyc(0, 1, 6, w);
      idle();
   endtask

   task automatic tick_once();
      cyc(1, 0, 0, 0);
      idle();
   endtask

   function automatic int rnd_val(int a);
      case (a)
         0, 1, 8, 9: return $urandom % 60;
         2, 10: return $urandom % 24;
         3, 11: return 1 + $urandom % 28;
         4, 12: return 1 + $urandom % 12;
         5, 13: return 1 + $urandom % 99;
         6, 14: return $urandom % 7;
         7: return $urandom % 128;
         default: return ($urandom % 2) * 128 + $urandom % 6;
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      started = 1;
      // R1 reset state (sampled before any tick)
      dchk("R1", "sec", sec_o, 0);   dchk("R1", "day", day_o, 1);
      dchk("R1", "month", mon_o, 1); dchk("R1", "year", year_o, 1);
      dchk("R1", "wday", wday_o, 0); dchk("R1", "flags", {alarm_flag, timer_flag}, 0);

      // R4 leap February
      set_time(4, 2, 28, 23, 59, 59, 3);
      tick_once();
      dchk("R4", "leap day", day_o, 29);
      dchk("R6", "wday step", wday_o, 4);
      set_time(4, 2, 29, 23, 59, 59, 6);
      tick_once();
      dchk("R3", "march after leap", mon_o, 3);
      dchk("R6", "wday wrap", wday_o, 0);
      // R4 common year
      set_time(3, 2, 28, 23, 59, 59, 1);
      tick_once();
      dchk("R4", "common feb end", day_o, 1);
      // R3 thirty-day month
      set_time(7, 4, 30, 23, 59, 59, 2);
      tick_once();
      dchk("R3", "april end", mon_o, 5);
      // R5 year wrap
      set_time(99, 12, 31, 23, 59, 59, 5);
      tick_once();
      dchk("R5", "year wrap", year_o, 1);
      dchk("R5", "month wrap", mon_o, 1);

      // R7 write coinciding with tick, carry into written minute dropped
      set_time(10, 6, 10, 5, 20, 59, 0);
      cyc(1, 1, 1, 33);
      idle();
      dchk("R7", "sec counted", sec_o, 0);
      dchk("R7", "min written", min_o, 33);
      dchk("R7", "hour untouched", hour_o, 5);
      cyc(1, 1, 0, 45);
      idle();
      dchk("R7", "sec written on tick", sec_o, 45);

      // R8 alarm on second and minute only
      set_time(10, 6, 10, 5, 0, 0, 0);
      cyc(0, 1, 8, 3); cyc(0, 1, 9, 0); cyc(0, 1, 7, 3);
      tick_once(); tick_once();
      dchk("R8", "no early alarm", alarm_flag, 0);
      cyc(1, 0, 0, 0);
      idle();
      dchk("R8", "alarm pulse", alarm_irq, 1);
      @(negedge clk); alarm_clr = 1;
      idle();
      dchk("R9", "alarm cleared", alarm_flag, 0);

      // R10 one-shot then repeat
      cyc(0, 1, 15, 3);
      tick_once(); tick_once();
      cyc(1, 0, 0, 0);
      idle();
      dchk("R10", "one-shot pulse", timer_irq, 1);
      cyc(0, 1, 15, 128 + 2);
      repeat (6) tick_once();
      dchk("R11", "timer flag", timer_flag, 1);
      cyc(0, 1, 15, 0);

      // long run of back-to-back ticks
      for (int i = 0; i < 4000; i++) cyc(1, 0, 0, 0);
      idle();

      // random phase with colliding writes and ticks
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         tick_1hz = ($urandom % 3) == 0;
         wr_en = ($urandom % 6) == 0;
         wr_addr = 4'($urandom % 16);
         wr_data = 8'(rnd_val(int'(wr_addr)));
         alarm_clr = ($urandom % 16) == 0;
         timer_clr = ($urandom % 16) == 0;
      end
      idle();
      idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule